// File: doc/BRIEF.md
# Trinary Pulse-Width Serial Encoder

This block serialises nine three-state digits onto a single output line. Each digit arrives as a 2-bit code meaning low, high or open. It is sent as two pulse slots, and the width of each pulse carries the value. A slot lasts four encoder clocks. A short pulse is high for one clock and a long pulse is high for three.

Pulling the active-low enable low starts an encoding sequence. The sequence sends the word, a silent gap of three digit periods, the same word again and a second gap. If the enable is still low when the sequence ends, the next sequence follows at once. Otherwise the block goes idle, holds its counters and keeps the line low. The codes are captured at the start of each word, so changes on the inputs never tear a word apart.

Top module: `tpw_encoder`

## Requirements
- R1: While reset is high and after it is released, `ser_out` is low and the block is idle.
- R2: Digit code 2'b00 (low) is sent as short, short. Code 2'b01 (high) is sent as long, long. Codes 2'b10 and 2'b11 (open) are sent as long, short.
- R3: A slot is 4 clocks. A short pulse is 1 clock high then 3 low. A long pulse is 3 clocks high then 1 low. A digit period is two slots, or 8 clocks.
- R4: Digits go out in order from digit 1 (`digit_codes[1:0]`) to digit 9 (`digit_codes[17:16]`).
- R5: One sequence is a word, then 24 clocks of low output, then the word again, then another 24 clocks of low output, for 192 output clocks in total.
- R6: From idle, if `tx_en_n` is sampled low at a clock edge, the first pulse of digit 1 appears on `ser_out` after the second following edge.
- R7: A one-cycle low pulse on `tx_en_n` produces exactly one complete sequence, after which the output stays low.
- R8: The enable is sampled at the edge that ends a sequence. If it is low there, the next sequence starts with no idle cycle. If it is high, the block goes idle.
- R9: A rising enable in the middle of a sequence does not shorten it.
- R10: The codes are captured on the edge that starts each word. An input change during a word shows up first in the next word, including a change just before the second word's start edge.
- R11: While idle, `ser_out` stays low and the slot, digit and gap counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_n | input | 1 | Active-low transmit enable |
| digit_codes | input | 18 | Nine 2-bit digit codes, digit 1 in the low bits |
| ser_out | output | 1 | Registered serial pulse-width output |

## Verification
Two events can fall on the same clock edge. The first is word capture, which coincides with an input change. The second is the end-of-sequence decision, which coincides with an enable edge. The bench changes the codes in the cycle just before the second word's capture edge, and expects the new codes in that word. It releases the enable one cycle before the decision edge in one run, and one cycle after it in another. The expected serial stream is then exactly one sequence in the first case and two back-to-back sequences in the second. A scoreboard compares every output clock against that stream.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WORD = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

  localparam logic [1:0] CODE_LOW  = 2'b00;
  localparam logic [1:0] CODE_HIGH = 2'b01;
endpackage

// File: rtl/tpw_slot_timer.sv
module tpw_slot_timer #(
  parameter int NUM_DIGITS = 9,
  parameter int SLOT_CLKS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run,
  output logic [$clog2(SLOT_CLKS)-1:0]  ph,
  output logic                          half,
  output logic [$clog2(NUM_DIGITS)-1:0] dig,
  output logic                          word_last
);
  localparam int PH_W  = $clog2(SLOT_CLKS);
  localparam int DIG_W = $clog2(NUM_DIGITS);
  localparam logic [PH_W-1:0]  PH_MAX  = PH_W'(SLOT_CLKS - 1);
  localparam logic [DIG_W-1:0] DIG_MAX = DIG_W'(NUM_DIGITS - 1);

  logic slot_end;
  assign slot_end  = (ph == PH_MAX);
  assign word_last = run && slot_end && half && (dig == DIG_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      half <= 1'b0;
      dig  <= '0;
    end else if (run) begin
      ph <= slot_end ? '0 : ph + 1'b1;
      if (slot_end) begin
        half <= ~half;
        if (half) dig <= (dig == DIG_MAX) ? '0 : dig + 1'b1;
      end
    end
  end

  AST_TIMER_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable({ph, half, dig})) else $error("slot timer moved while stopped"); // R11
endmodule

// File: rtl/tpw_gap_timer.sv
module tpw_gap_timer #(
  parameter int GAP_CLKS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic gap_last
);
  localparam int GAP_W = $clog2(GAP_CLKS);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CLKS - 1);

  logic [GAP_W-1:0] gap_q;
  assign gap_last = run && (gap_q == GAP_MAX);

  always_ff @(posedge clk) begin
    if (rst)      gap_q <= '0;
    else if (run) gap_q <= (gap_q == GAP_MAX) ? '0 : gap_q + 1'b1;
  end

  AST_GAP_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(gap_q)) else $error("gap timer moved while stopped"); // R11
endmodule

// File: rtl/tpw_pulse_gen.sv
module tpw_pulse_gen
  import tpw_pkg::*;
#(
  parameter int NUM_DIGITS = 9,
  parameter int SLOT_CLKS  = 4,
  parameter int SHORT_HI   = 1,
  parameter int LONG_HI    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          active,
  input  logic [2*NUM_DIGITS-1:0]       codes,
  input  logic [$clog2(SLOT_CLKS)-1:0]  ph,
  input  logic                          half,
  input  logic [$clog2(NUM_DIGITS)-1:0] dig,
  output logic                          ser_out
);
  localparam int PH_W = $clog2(SLOT_CLKS);
  localparam logic [PH_W:0] SHORT_LEN = (PH_W+1)'(SHORT_HI);
  localparam logic [PH_W:0] LONG_LEN  = (PH_W+1)'(LONG_HI);

  logic [1:0]    cur_code;
  logic          is_long;
  logic [PH_W:0] hi_len;

  always_comb begin
    cur_code = codes[2*int'(dig) +: 2];
    // first slot is long unless the digit is low; second slot only for high
    is_long  = half ? (cur_code == CODE_HIGH) : (cur_code != CODE_LOW);
    hi_len   = is_long ? LONG_LEN : SHORT_LEN;
  end

  always_ff @(posedge clk) begin
    if (rst) ser_out <= 1'b0;
    else     ser_out <= active && ({1'b0, ph} < hi_len);
  end

  AST_PULSE_LEADS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (active && ph == '0) |=> ser_out) else $error("slot did not start high"); // R3
  AST_PULSE_TRAILS_LOW: assert property (@(posedge clk) disable iff (rst)
    (active && ph == PH_W'(SLOT_CLKS - 1)) |=> !ser_out) else $error("slot did not end low"); // R3
  AST_QUIET_OFF_WORD: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ser_out) else $error("output high outside a word"); // R5
endmodule

// File: rtl/tpw_encoder.sv
module tpw_encoder
  import tpw_pkg::*;
#(
  parameter int NUM_DIGITS  = 9,
  parameter int SLOT_CLKS   = 4,
  parameter int SHORT_HI    = 1,
  parameter int LONG_HI     = 3,
  parameter int GAP_PERIODS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_en_n,
  input  logic [2*NUM_DIGITS-1:0] digit_codes,
  output logic                    ser_out
);
  localparam int PH_W     = $clog2(SLOT_CLKS);
  localparam int DIG_W    = $clog2(NUM_DIGITS);
  localparam int GAP_CLKS = GAP_PERIODS * 2 * SLOT_CLKS;

  seq_state_e              state_q;
  logic                    second_q;
  logic [2*NUM_DIGITS-1:0] shadow_q;
  logic [PH_W-1:0]         ph;
  logic                    half;
  logic [DIG_W-1:0]        dig;
  logic                    word_last;
  logic                    gap_last;
  logic                    in_word;
  logic                    in_gap;

  assign in_word = (state_q == SEQ_WORD);
  assign in_gap  = (state_q == SEQ_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      second_q <= 1'b0;
      shadow_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (!tx_en_n) begin
          state_q  <= SEQ_WORD;
          second_q <= 1'b0;
          shadow_q <= digit_codes;
        end
        SEQ_WORD: if (word_last) state_q <= SEQ_GAP;
        SEQ_GAP: if (gap_last) begin
          if (!second_q) begin
            state_q  <= SEQ_WORD;
            second_q <= 1'b1;
            shadow_q <= digit_codes;
          end else if (!tx_en_n) begin
            state_q  <= SEQ_WORD;
            second_q <= 1'b0;
            shadow_q <= digit_codes;
          end else begin
            state_q  <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  tpw_slot_timer #(.NUM_DIGITS(NUM_DIGITS), .SLOT_CLKS(SLOT_CLKS)) u_slot (
    .clk(clk), .rst(rst), .run(in_word),
    .ph(ph), .half(half), .dig(dig), .word_last(word_last)
  );

  tpw_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk(clk), .rst(rst), .run(in_gap), .gap_last(gap_last)
  );

  tpw_pulse_gen #(
    .NUM_DIGITS(NUM_DIGITS), .SLOT_CLKS(SLOT_CLKS),
    .SHORT_HI(SHORT_HI), .LONG_HI(LONG_HI)
  ) u_pulse (
    .clk(clk), .rst(rst), .active(in_word), .codes(shadow_q),
    .ph(ph), .half(half), .dig(dig), .ser_out(ser_out)
  );

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_IDLE && !tx_en_n) |=> in_word) else $error("enable ignored"); // R6
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
    in_word |=> $stable(shadow_q)) else $error("codes changed inside a word"); // R10
  AST_WORD_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
    in_word |=> state_q != SEQ_IDLE) else $error("sequence cut short"); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (state_q == SEQ_IDLE && !ser_out)) else $error("reset not idle"); // R1
endmodule

// File: tb/tpw_encoder_bench.sv
`timescale 1ns/1ps
module tpw_encoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en_n = 1'b1;
  logic [17:0] digit_codes = '0;
  logic        ser_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  // digit1=00 digit2=01 digit3=10 digit4=11 digit5=01 digit6=00 digit7=10 digit8=01 digit9=00
  localparam logic [17:0] PAT_A = {2'b00, 2'b01, 2'b10, 2'b00, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
  localparam logic [17:0] PAT_B = {9{2'b01}};
  localparam logic [17:0] PAT_C = {2'b01, 2'b10, 2'b00, 2'b00, 2'b11, 2'b01, 2'b01, 2'b10, 2'b10};

  always #4 clk = ~clk;

  tpw_encoder u_tpw_encoder (
    .clk(clk), .rst(rst), .tx_en_n(tx_en_n),
    .digit_codes(digit_codes), .ser_out(ser_out)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: ser_out=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic push_word(input logic [17:0] c, input string tag);
    for (int d = 0; d < 9; d++) begin
      for (int s = 0; s < 2; s++) begin
        logic [1:0] code;
        bit lng;
        code = c[2*d +: 2];
        lng  = (s == 0) ? (code != 2'b00) : (code == 2'b01);
        for (int p = 0; p < 4; p++) begin
          exp_q.push_back(p < (lng ? 3 : 1));
          tag_q.push_back(tag);
        end
      end
    end
  endtask

  task automatic push_gap(input string tag);
    for (int i = 0; i < 24; i++) begin
      exp_q.push_back(1'b0);
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_seq(input logic [17:0] w1, input logic [17:0] w2, input string tag);
    push_word(w1, tag);
    push_gap({tag, " R5 gap"});
    push_word(w2, tag);
    push_gap({tag, " R5 gap"});
  endtask

  // enable low after the next rising edge; two output clocks precede digit 1 (R6)
  task automatic start_seq();
    @(posedge clk); #2;
    tx_en_n = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exp_q.push_back(1'b0);
      tag_q.push_back("R6 latency");
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  // scoreboard monitor: compares every output clock at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() != 0) chk(ser_out, exp_q.pop_front(), tag_q.pop_front());
      else                   chk(ser_out, 1'b0, "R11 idle low");
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_out, 1'b0, "R1 in reset");
    @(posedge clk); #2; rst = 1'b0;
    repeat (4) @(posedge clk);

    // one-cycle enable pulse: mixed codes, order, widths, one sequence only (R2 R3 R4 R7 R9)
    digit_codes = PAT_A;
    start_seq();
    push_seq(PAT_A, PAT_A, "R2 R3 R4 R7 one-shot");
    @(posedge clk); #2; tx_en_n = 1'b1;
    drain();

    // all high codes, one-shot (R2)
    digit_codes = PAT_B;
    start_seq();
    push_seq(PAT_B, PAT_B, "R2 all-high");
    @(posedge clk); #2; tx_en_n = 1'b1;
    drain();

    // code change inside word 1 and just before word 2 capture; release one cycle before decision (R10 R8)
    digit_codes = PAT_A;
    start_seq();
    push_seq(PAT_A, PAT_C, "R10 capture");
    repeat (11) @(posedge clk); #2; digit_codes = PAT_B;
    repeat (85) @(posedge clk); #2; digit_codes = PAT_C;
    repeat (96) @(posedge clk); #2; tx_en_n = 1'b1;
    drain();

    // release one cycle after the decision edge: two back-to-back sequences (R8)
    digit_codes = PAT_C;
    start_seq();
    push_seq(PAT_C, PAT_C, "R8 first");
    push_seq(PAT_C, PAT_C, "R8 repeat");
    repeat (193) @(posedge clk); #2; tx_en_n = 1'b1;
    drain();

    // enable released mid-word 1 still yields a full sequence (R9)
    digit_codes = PAT_A;
    start_seq();
    push_seq(PAT_A, PAT_A, "R9 mid release");
    repeat (40) @(posedge clk); #2; tx_en_n = 1'b1;
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, queue=%0d expected=0", exp_q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule